// File: doc/BRIEF.md
# Cascadable Dual 32-bit Timer

This block holds two 32-bit timers. Each timer has a counter, a period register and a small control register, all written through a byte-wide register port. A timer counts either every system clock or each rising edge of its own external timer clock input. That input is first brought into the clock domain through a two-flop synchroniser.

When the counter equals the period, the timer raises its expiry pin for one clock and sets a sticky interrupt flag. What it does next depends on its mode. In periodic mode it wraps to zero. In one-shot mode it holds its value and drops its own enable bit.

The second timer can be cascaded behind the first. It then advances once per expiry of the first timer, so the two form one long chain. The register port is a plain one-cycle write strobe with an address, plus a combinational read of the addressed byte. It has no handshake, because every access completes in one cycle.

Top module: `tmr_pair`

## Requirements
- R1: After reset, both expiry pins and both interrupt pins are low, and every period, count and control byte reads as 0.
- R2: Timer t (t = 0 or 1) occupies addresses 16*t to 16*t+15. Its period sits at offsets 0..3, least significant byte first. Writes to offsets 0..2 only stage bytes. The value written to offset 3 commits all four bytes at once, and this write also clears the counter.
- R3: In one-shot mode (control bit1 = 0) with the system clock as source, the expiry pulse appears P+1 cycles after the enabling write, where P is the period. Afterwards control bit0 (enable) reads 0 and the count holds at P.
- R4: In periodic mode (control bit1 = 1), the counter returns to 0 on the cycle after a match. Expiry pulses repeat every P+1 ticks.
- R5: Each expiry pulse lasts exactly one clock cycle.
- R6: The interrupt flag is offset 9, bit0. Expiry sets it, and it stays set until a write of 1 to that bit. Writing 0 to it has no effect.
- R7: With control bit2 = 1, the timer counts its external clock input. It advances by one per rising edge, and a held level adds no counts.
- R8: With timer 1's control bit3 = 1 (cascade), timer 1 advances once per expiry of timer 0 and ignores its own source selection and external input.
- R9: A control write that sets enable while the enable bit is 0 restarts the counter from 0.
- R10: The control byte is offset 8: bit0 enable, bit1 periodic, bit2 external source, bit3 cascade. Bit3 is implemented on timer 1 only and reads 0 on timer 0. The live count reads at offsets 4..7, least significant byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe, one access per cycle |
| reg_addr | input | 5 | Register address; bit4 selects the timer |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Combinational read of the addressed byte |
| tmr_clk_i | input | 2 | External timer clock per timer, asynchronous |
| tmr_exp_o | output | 2 | One-cycle expiry pulse per timer |
| tmr_irq_o | output | 2 | Sticky interrupt flag per timer |

## Verification
The count path is driven three ways: by the system clock in one-shot and periodic modes, by a slow external clock with long high and low phases, and through the cascade from timer 0. The exact cycle of each expiry separates an off-by-one in the match from a wrong reload value. The external-clock run counts edges while the input is held high, which shows that a level is not mistaken for repeated edges. In the cascade run, timer 1's external input toggles every cycle, so any leak from its own source would change when it expires.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam logic [3:0] OFS_PER  = 4'h0;
  localparam logic [3:0] OFS_CNT  = 4'h4;
  localparam logic [3:0] OFS_CTRL = 4'h8;
  localparam logic [3:0] OFS_STAT = 4'h9;

  localparam int CTL_EN   = 0;
  localparam int CTL_PER  = 1;
  localparam int CTL_EXT  = 2;
  localparam int CTL_CASC = 3;

  typedef struct packed {
    logic casc;
    logic ext;
    logic periodic;
    logic en;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_edge_det.sv
`timescale 1ns/1ps
module tmr_edge_det #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [SYNC_N:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[SYNC_N-1:0], async_i};
  end

  assign rise_o = pipe_q[SYNC_N-1] & ~pipe_q[SYNC_N];
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             en_i,
  input  logic             periodic_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o,
  output logic             exp_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;
  logic             match;

  assign match = (cnt_q == period_i);
  assign hit_o = en_i & match & ~exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= hit_o;
      if (restart_i)                      cnt_q <= '0;
      else if (hit_o && periodic_i)       cnt_q <= '0;
      else if (en_i && tick_i && !match)  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign exp_o = exp_q;
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter bit CASC_OK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [3:0]       offset_i,
  input  logic [7:0]       wdata_i,
  input  logic             hw_stop_i,
  input  logic             hw_set_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] period_o,
  output tmr_ctrl_t        ctrl_o,
  output logic             flag_o,
  output logic             restart_o,
  output logic [7:0]       rdata_o
);
  localparam int NB   = CNT_W / 8;
  localparam int SH_W = CNT_W - 8;

  logic [SH_W-1:0]  shadow_q;
  logic [CNT_W-1:0] period_q;
  tmr_ctrl_t        ctrl_q;
  tmr_ctrl_t        wctrl;
  logic             flag_q;
  logic             wr_top, wr_ctrl, wr_stat;

  assign wr_top  = wr_en_i && (offset_i == OFS_PER + 4'(NB - 1));
  assign wr_ctrl = wr_en_i && (offset_i == OFS_CTRL);
  assign wr_stat = wr_en_i && (offset_i == OFS_STAT);

  always_comb begin
    wctrl.casc     = CASC_OK & wdata_i[CTL_CASC];
    wctrl.ext      = wdata_i[CTL_EXT];
    wctrl.periodic = wdata_i[CTL_PER];
    wctrl.en       = wdata_i[CTL_EN];
  end

  assign restart_o = wr_top | (wr_ctrl & wctrl.en & ~ctrl_q.en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      period_q <= '0;
    end else begin
      for (int b = 0; b < NB - 1; b++) begin
        if (wr_en_i && offset_i == OFS_PER + 4'(b))
          shadow_q[b*8 +: 8] <= wdata_i;
      end
      if (wr_top) period_q <= {wdata_i, shadow_q};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          ctrl_q <= '0;
    else if (wr_ctrl)    ctrl_q <= wctrl;
    else if (hw_stop_i)  ctrl_q.en <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       flag_q <= 1'b0;
    else if (hw_set_i)                flag_q <= 1'b1;
    else if (wr_stat && wdata_i[0])   flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int b = 0; b < NB; b++) begin
      if (offset_i == OFS_PER + 4'(b)) rdata_o = period_q[b*8 +: 8];
      if (offset_i == OFS_CNT + 4'(b)) rdata_o = cnt_i[b*8 +: 8];
    end
    if (offset_i == OFS_CTRL) rdata_o = {4'b0000, ctrl_q};
    if (offset_i == OFS_STAT) rdata_o = {7'b0000000, flag_q};
  end

  assign period_o = period_q;
  assign ctrl_o   = ctrl_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/tmr_pair.sv
`timescale 1ns/1ps
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr_en,
  input  logic [4:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [1:0] tmr_clk_i,
  output logic [1:0] tmr_exp_o,
  output logic [1:0] tmr_irq_o
);
  localparam int N_TMR = 2;

  logic [N_TMR-1:0][CNT_W-1:0] cnt_v;
  logic [N_TMR-1:0][CNT_W-1:0] per_v;
  logic [N_TMR-1:0][7:0]       rd_v;
  logic [N_TMR-1:0]            hit_v, rise_v, tick_v, restart_v, per_mode_v;
  tmr_ctrl_t                   ctrl_v [N_TMR];
  logic                        casc_v;

  assign casc_v = ctrl_v[1].casc;

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    tmr_edge_det #(.SYNC_N(SYNC_N)) u_edge (
      .clk(clk), .rst_n(rst_n), .async_i(tmr_clk_i[t]), .rise_o(rise_v[t])
    );

    if (t == 0) begin : g_src
      assign tick_v[t] = ctrl_v[t].ext ? rise_v[t] : 1'b1;
    end else begin : g_src
      assign tick_v[t] = ctrl_v[t].casc ? hit_v[0]
                       : (ctrl_v[t].ext ? rise_v[t] : 1'b1);
    end

    assign per_mode_v[t] = ctrl_v[t].periodic;

    tmr_regs #(.CNT_W(CNT_W), .CASC_OK(t == 1)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(reg_wr_en && reg_addr[4] == 1'(t)),
      .offset_i(reg_addr[3:0]), .wdata_i(reg_wdata),
      .hw_stop_i(hit_v[t] & ~ctrl_v[t].periodic),
      .hw_set_i(hit_v[t]), .cnt_i(cnt_v[t]),
      .period_o(per_v[t]), .ctrl_o(ctrl_v[t]), .flag_o(tmr_irq_o[t]),
      .restart_o(restart_v[t]), .rdata_o(rd_v[t])
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .restart_i(restart_v[t]),
      .en_i(ctrl_v[t].en), .periodic_i(per_mode_v[t]), .tick_i(tick_v[t]),
      .period_i(per_v[t]), .cnt_o(cnt_v[t]), .hit_o(hit_v[t]),
      .exp_o(tmr_exp_o[t])
    );
  end

  assign reg_rdata = rd_v[reg_addr[4]];
endmodule

// File: rtl/tmr_pair_chk.sv
`timescale 1ns/1ps
module tmr_pair_chk #(
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr_en,
  input logic [4:0]            reg_addr,
  input logic [7:0]            reg_wdata,
  input logic [1:0]            tmr_exp_o,
  input logic [1:0]            tmr_irq_o,
  input logic [1:0][CNT_W-1:0] cnt_v,
  input logic [1:0][CNT_W-1:0] per_v,
  input logic                  casc_v
);
  localparam int NB = CNT_W / 8;

  for (genvar i = 0; i < 2; i++) begin : g_chk
    localparam logic [4:0] TOP_A  = 5'(i*16 + NB - 1);
    localparam logic [4:0] STAT_A = 5'(i*16 + 9);

    a_r2_period_commit: assert property (@(posedge clk) disable iff (!rst_n)
      per_v[i] != $past(per_v[i]) |-> $past(reg_wr_en && reg_addr == TOP_A));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_exp_o[i] |=> !tmr_exp_o[i]);

    a_r6_irq_from_exp: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_irq_o[i]) |-> tmr_exp_o[i]);

    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_irq_o[i] && !(reg_wr_en && reg_addr == STAT_A && reg_wdata[0])
      |=> tmr_irq_o[i]);

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_v[i] <= per_v[i]);
  end

  a_r8_casc_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(casc_v) && cnt_v[1] != $past(cnt_v[1]) && cnt_v[1] != '0
    |-> tmr_exp_o[0]);
endmodule

bind tmr_pair tmr_pair_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tmr_exp_o(tmr_exp_o), .tmr_irq_o(tmr_irq_o),
  .cnt_v(cnt_v), .per_v(per_v), .casc_v(casc_v)
);

// File: tb/tmr_pair_tb_top.sv
`timescale 1ns/1ps
module tmr_pair_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] tmr_clk_i = '0;
  logic [1:0] tmr_exp_o, tmr_irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tmr_pair dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_clk_i(tmr_clk_i),
    .tmr_exp_o(tmr_exp_o), .tmr_irq_o(tmr_irq_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd32(input int t, input int ofs, output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(5'(t*16 + ofs + i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic set_period(input int t, input logic [31:0] p);
    for (int i = 0; i < 4; i++) wr(5'(t*16 + i), p[i*8 +: 8]);
  endtask

  // watch n cycles after an edge; record first two pulse positions and total
  task automatic watch(input int t, input int n, input bit tog1,
                       output int first, output int second, output int highs);
    first = -1; second = -1; highs = 0;
    for (int k = 1; k <= n; k++) begin
      if (tog1) tmr_clk_i[1] = ~tmr_clk_i[1];
      @(negedge clk);
      if (tmr_exp_o[t]) begin
        highs++;
        if (first < 0) first = k; else if (second < 0) second = k;
      end
    end
  endtask

  task automatic t_reset;
    logic [31:0] v; logic [7:0] b;
    chk(tmr_exp_o == 2'b00 && tmr_irq_o == 2'b00, "R1 pins", {tmr_exp_o, tmr_irq_o}, 0);
    rd32(0, 0, v); chk(v == 0, "R1 period0", v, 0);
    rd32(1, 4, v); chk(v == 0, "R1 count1", v, 0);
    rd(5'd8, b);   chk(b == 0, "R1 ctrl0", b, 0);
  endtask

  task automatic t_commit;
    logic [31:0] v;
    wr(5'd16, 8'h44); wr(5'd17, 8'h33); wr(5'd18, 8'h22);
    rd32(1, 0, v); chk(v == 0, "R2 staged not visible", v, 0);
    wr(5'd19, 8'h11);
    rd32(1, 0, v); chk(v == 32'h11223344, "R2 committed", v, 32'h11223344);
  endtask

  task automatic t_oneshot;
    int f, s, h; logic [31:0] v; logic [7:0] b;
    set_period(0, 5);
    wr(5'd8, 8'h01);
    watch(0, 20, 1'b0, f, s, h);
    chk(f == 6, "R3 expiry cycle", f, 6);
    chk(h == 1, "R5 single pulse", h, 1);
    rd(5'd8, b);   chk(b == 8'h00, "R3 enable cleared", b, 0);
    rd32(0, 4, v); chk(v == 5, "R3 count holds", v, 5);
    chk(tmr_irq_o[0] == 1'b1, "R6 flag set", tmr_irq_o[0], 1);
    wr(5'd9, 8'h00);
    chk(tmr_irq_o[0] == 1'b1, "R6 write 0 ignored", tmr_irq_o[0], 1);
    wr(5'd9, 8'h01);
    chk(tmr_irq_o[0] == 1'b0, "R6 write 1 clears", tmr_irq_o[0], 0);
    wr(5'd8, 8'h01);
    watch(0, 20, 1'b0, f, s, h);
    chk(f == 6, "R9 restart from zero", f, 6);
  endtask

  task automatic t_periodic;
    int f, s, h; logic [31:0] v;
    set_period(0, 3);
    wr(5'd8, 8'h03);
    watch(0, 9, 1'b0, f, s, h);
    chk(f == 4, "R4 first expiry", f, 4);
    chk(s - f == 4, "R4 interval", s - f, 4);
    chk(h == 2, "R5 pulse count", h, 2);
    rd32(0, 4, v); chk(v == 1, "R4 wrapped count", v, 1);
    wr(5'd8, 8'h00); wr(5'd9, 8'h01);
  endtask

  task automatic t_ext;
    logic [31:0] v;
    set_period(0, 100);
    wr(5'd8, 8'h05);
    for (int e = 0; e < 5; e++) begin
      tmr_clk_i[0] = 1'b1; repeat (3) @(negedge clk);
      tmr_clk_i[0] = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd32(0, 4, v); chk(v == 5, "R7 edges counted", v, 5);
    tmr_clk_i[0] = 1'b1; repeat (12) @(negedge clk);
    rd32(0, 4, v); chk(v == 6, "R7 held level", v, 6);
    tmr_clk_i[0] = 1'b0;
    wr(5'd8, 8'h00);
  endtask

  task automatic t_cascade;
    int f, s, h; logic [31:0] v; logic [7:0] b;
    wr(5'd8, 8'h08);
    rd(5'd8, b); chk(b == 8'h00, "R10 no cascade bit on timer0", b, 0);
    set_period(1, 2);
    set_period(0, 3);
    wr(5'd24, 8'h0D);
    rd(5'd24, b); chk(b == 8'h0D, "R10 ctrl readback", b, 8'h0D);
    wr(5'd8, 8'h03);
    watch(1, 12, 1'b1, f, s, h);
    chk(f == 9, "R8 cascade expiry", f, 9);
    rd32(1, 4, v); chk(v == 2, "R8 cascade count", v, 2);
    wr(5'd8, 8'h00);
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_commit();
    t_oneshot();
    t_periodic();
    t_ext();
    t_cascade();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule